// File: doc/BRIEF.md
# DMA Bus Error Capture Unit

This block sits beside a DMA engine that masters two buses, a primary system bus and a secondary local bus. It records which access failed and which peripheral channel issued it, keeps one error flag per bus, and raises a single maskable interrupt. Software reaches the flags, the mask and the captured values through a small word-addressed register port. Reads are combinational, and writes take effect on the next rising clock edge.

For each bus the block keeps an error address register and a requester identity register. The local-bus address register follows every local access and stops when the local error flag is raised. The primary-bus address register loads only on the cycle that reports a primary error. The identity of the requester is taken when a transaction starts and is held until that transaction completes. Identity capture also stops while the bus's error flag is set.

Top module: `dma_err_capture`

## Requirements
- R1: The mask register is 8 bits wide, is read and written at word address 1 (bits 7:0, upper bits read 0), and clears to 0x00 on reset.
- R2: The status register at word address 0 has bit 0 = primary-bus error and bit 1 = local-bus error. Bits 7:2 always read 0. A bit is set one edge after its error pulse, and writing 1 to a bit clears it.
- R3: When an error pulse and a write-1-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R4: `irq_o` is the registered OR of (status AND mask). It changes one clock edge after the status or mask register changes, and it resets to 0.
- R5: The local error address register (word 4) loads `loc_addr_i` on every cycle with `loc_acc_i` high while status bit 1 is clear, including the cycle that reports the error. It holds its value while status bit 1 is set.
- R6: The primary error address register (word 2) loads `pri_addr_i` only on a cycle with `pri_err_i` high while status bit 0 is clear. Accesses without an error leave it unchanged.
- R7: Each identity register (word 3 primary, word 5 local) reads {26'b0, dir, code[4:0]}, where dir is 0 for transmit and 1 for receive. It loads when an access starts with no transaction outstanding, or in the same cycle as a done. It then holds until that transaction's done.
- R8: An identity register does not load while the error flag of its bus is set.
- R9: Writes to words 2 to 5 have no effect on the read value. Words 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pri_acc_i | input | 1 | Primary-bus access start |
| pri_done_i | input | 1 | Primary-bus transaction complete |
| pri_err_i | input | 1 | Primary-bus error pulse |
| pri_addr_i | input | 32 | Primary-bus access address |
| pri_code_i | input | 5 | Primary requester sub-block code |
| pri_dir_i | input | 1 | Primary requester direction (0 tx, 1 rx) |
| loc_acc_i | input | 1 | Local-bus access start |
| loc_done_i | input | 1 | Local-bus transaction complete |
| loc_err_i | input | 1 | Local-bus error pulse |
| loc_addr_i | input | 32 | Local-bus access address |
| loc_code_i | input | 5 | Local requester sub-block code |
| loc_dir_i | input | 1 | Local requester direction (0 tx, 1 rx) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Combined masked error interrupt |

## Verification
The properties assume that the error pulses and the access, done and write strobes are single-cycle and are sampled only on rising edges. They also assume that a done arrives only for a transaction that has started. The address and identity registers have no reset value, so the properties check only how they hold or change, never their absolute value after reset. The stimulus drives every strobe for exactly one clock, changes inputs only on falling edges, and reads an address or identity register only after a capture has loaded it.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  localparam int unsigned STS_W  = 8;
  localparam int unsigned REG_AW = 3;

  localparam int unsigned STS_PRI = 0;
  localparam int unsigned STS_LOC = 1;

  typedef enum logic [REG_AW-1:0] {
    RA_STS     = 3'd0,
    RA_MSK     = 3'd1,
    RA_PRI_ADR = 3'd2,
    RA_PRI_ID  = 3'd3,
    RA_LOC_ADR = 3'd4,
    RA_LOC_ID  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/dma_err_bus_track.sv
module dma_err_bus_track #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CODE_W    = 5,
  parameter bit          TRACK_ALL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              dir_i,
  input  logic              frozen_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic              dir_o,
  output logic              busy_o
);
  logic              busy_q;
  logic              addr_ld;
  logic              id_ld;
  logic [ADDR_W-1:0] addr_q;
  logic [CODE_W-1:0] code_q;
  logic              dir_q;

  generate
    if (TRACK_ALL) begin : g_track
      assign addr_ld = acc_i && !frozen_i;
    end else begin : g_on_err
      assign addr_ld = err_i && !frozen_i;
    end
  endgenerate

  assign id_ld = acc_i && (!busy_q || done_i) && !frozen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (acc_i)  busy_q <= 1'b1;
    else if (done_i) busy_q <= 1'b0;
  end

  // capture registers carry no reset value
  always_ff @(posedge clk_i) begin
    if (addr_ld) addr_q <= addr_i;
    if (id_ld) begin
      code_q <= code_i;
      dir_q  <= dir_i;
    end
  end

  assign addr_o = addr_q;
  assign code_o = code_q;
  assign dir_o  = dir_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
  import dma_err_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [STS_W-1:0]   clr_i,
  input  logic               msk_we_i,
  input  logic [STS_W-1:0]   msk_wdata_i,
  output logic [STS_W-1:0]   sts_o,
  output logic [STS_W-1:0]   msk_o,
  output logic               irq_o
);
  logic [STS_W-1:0] sts_q, msk_q, set_ext;
  logic             irq_q;

  assign set_ext = STS_W'(set_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_ext;  // set wins
      if (msk_we_i) msk_q <= msk_wdata_i;
      irq_q <= |(sts_q & msk_q);
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_acc_i,
  input  logic              pri_done_i,
  input  logic              pri_err_i,
  input  logic [ADDR_W-1:0] pri_addr_i,
  input  logic [CODE_W-1:0] pri_code_i,
  input  logic              pri_dir_i,
  input  logic              loc_acc_i,
  input  logic              loc_done_i,
  input  logic              loc_err_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [CODE_W-1:0] loc_code_i,
  input  logic              loc_dir_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned ID_W = CODE_W + 1;

  logic [STS_W-1:0]  sts_w, msk_w, clr_w;
  logic              msk_we_w;
  logic [ADDR_W-1:0] pri_adr_w, loc_adr_w;
  logic [CODE_W-1:0] pri_code_w, loc_code_w;
  logic              pri_dir_w, loc_dir_w;
  logic              pri_busy_w, loc_busy_w;

  assign clr_w    = (reg_we_i && reg_addr_i == RA_STS) ? reg_wdata_i[STS_W-1:0] : '0;
  assign msk_we_w = reg_we_i && reg_addr_i == RA_MSK;

  dma_err_status #(.NUM_SRC(2)) i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       ({loc_err_i, pri_err_i}),
    .clr_i       (clr_w),
    .msk_we_i    (msk_we_w),
    .msk_wdata_i (reg_wdata_i[STS_W-1:0]),
    .sts_o       (sts_w),
    .msk_o       (msk_w),
    .irq_o       (irq_o)
  );

  dma_err_bus_track #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .TRACK_ALL(1'b0)) i_pri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (pri_acc_i),
    .done_i   (pri_done_i),
    .err_i    (pri_err_i),
    .addr_i   (pri_addr_i),
    .code_i   (pri_code_i),
    .dir_i    (pri_dir_i),
    .frozen_i (sts_w[STS_PRI]),
    .addr_o   (pri_adr_w),
    .code_o   (pri_code_w),
    .dir_o    (pri_dir_w),
    .busy_o   (pri_busy_w)
  );

  dma_err_bus_track #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .TRACK_ALL(1'b1)) i_loc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (loc_acc_i),
    .done_i   (loc_done_i),
    .err_i    (loc_err_i),
    .addr_i   (loc_addr_i),
    .code_i   (loc_code_i),
    .dir_i    (loc_dir_i),
    .frozen_i (sts_w[STS_LOC]),
    .addr_o   (loc_adr_w),
    .code_o   (loc_code_w),
    .dir_o    (loc_dir_w),
    .busy_o   (loc_busy_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_STS:     reg_rdata_o[STS_W-1:0]  = sts_w;
      RA_MSK:     reg_rdata_o[STS_W-1:0]  = msk_w;
      RA_PRI_ADR: reg_rdata_o[ADDR_W-1:0] = pri_adr_w;
      RA_PRI_ID:  reg_rdata_o[ID_W-1:0]   = {pri_dir_w, pri_code_w};
      RA_LOC_ADR: reg_rdata_o[ADDR_W-1:0] = loc_adr_w;
      RA_LOC_ID:  reg_rdata_o[ID_W-1:0]   = {loc_dir_w, loc_code_w};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_err_capture_chk.sv
module dma_err_capture_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        sts,
  input logic [7:0]        msk,
  input logic              irq,
  input logic              pri_err,
  input logic              loc_err,
  input logic              loc_done,
  input logic              loc_busy,
  input logic [ADDR_W-1:0] pri_adr,
  input logic [ADDR_W-1:0] loc_adr,
  input logic [CODE_W-1:0] loc_code,
  input logic              loc_dir
);
  p_irq_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq == $past(|(sts & msk)));

  p_set_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_err |=> sts[1]);

  p_loc_addr_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sts[1]) |-> $stable(loc_adr));

  p_pri_addr_on_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pri_err) |-> $stable(pri_adr));

  p_id_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(loc_busy && !loc_done) |-> ($stable(loc_code) && $stable(loc_dir)));

  p_id_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sts[1]) |-> ($stable(loc_code) && $stable(loc_dir)));
endmodule

bind dma_err_capture dma_err_capture_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sts      (sts_w),
  .msk      (msk_w),
  .irq      (irq_o),
  .pri_err  (pri_err_i),
  .loc_err  (loc_err_i),
  .loc_done (loc_done_i),
  .loc_busy (loc_busy_w),
  .pri_adr  (pri_adr_w),
  .loc_adr  (loc_adr_w),
  .loc_code (loc_code_w),
  .loc_dir  (loc_dir_w)
);

// File: tb/test_dma_err_capture.sv
module test_dma_err_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pri_acc_i = 0, pri_done_i = 0, pri_err_i = 0, pri_dir_i = 0;
  logic [31:0] pri_addr_i = '0;
  logic [4:0]  pri_code_i = '0;
  logic        loc_acc_i = 0, loc_done_i = 0, loc_err_i = 0, loc_dir_i = 0;
  logic [31:0] loc_addr_i = '0;
  logic [4:0]  loc_code_i = '0;
  logic        reg_we_i = 0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  dma_err_capture i_dma_err_capture (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic loc_cyc(bit acc, bit done, bit err, logic [31:0] a, logic [4:0] c, bit dir);
    @(negedge clk_i);
    loc_acc_i = acc; loc_done_i = done; loc_err_i = err;
    loc_addr_i = a; loc_code_i = c; loc_dir_i = dir;
    @(negedge clk_i);
    loc_acc_i = 0; loc_done_i = 0; loc_err_i = 0;
  endtask

  task automatic pri_cyc(bit acc, bit done, bit err, logic [31:0] a, logic [4:0] c, bit dir);
    @(negedge clk_i);
    pri_acc_i = acc; pri_done_i = done; pri_err_i = err;
    pri_addr_i = a; pri_code_i = c; pri_dir_i = dir;
    @(negedge clk_i);
    pri_acc_i = 0; pri_done_i = 0; pri_err_i = 0;
  endtask

  task automatic t_reset;
    rd_chk("R2 status reset", 3'd0, 32'h0);
    rd_chk("R1 mask reset", 3'd1, 32'h0);
    chk("R4 irq reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_mask_rw;
    wr(3'd1, 32'hFFFF_FFA5);
    rd_chk("R1 mask rw", 3'd1, 32'h0000_00A5);
    wr(3'd0, 32'hFFFF_FFFC);
    rd_chk("R2 reserved status bits", 3'd0, 32'h0);
    wr(3'd1, 32'h0000_0002);
  endtask

  task automatic t_loc_track;
    loc_cyc(1, 0, 0, 32'h0000_1100, 5'd3, 0);
    rd_chk("R5 local addr tracks", 3'd4, 32'h0000_1100);
    rd_chk("R7 local id on start", 3'd5, 32'h0000_0003);
    loc_cyc(1, 0, 0, 32'h0000_1200, 5'd7, 1);
    rd_chk("R5 local addr tracks second", 3'd4, 32'h0000_1200);
    rd_chk("R7 local id held while outstanding", 3'd5, 32'h0000_0003);
    loc_cyc(0, 1, 0, 32'h0, 5'd0, 0);
    loc_cyc(1, 0, 0, 32'h0000_1300, 5'd9, 1);
    rd_chk("R7 local id new after done", 3'd5, 32'h0000_0029);
    loc_cyc(1, 1, 0, 32'h0000_1400, 5'd17, 0);
    rd_chk("R7 local id on done+start", 3'd5, 32'h0000_0011);
    loc_cyc(0, 1, 0, 32'h0, 5'd0, 0);
  endtask

  task automatic t_loc_err;
    @(negedge clk_i);
    loc_acc_i = 1; loc_err_i = 1; loc_addr_i = 32'hDEAD_0040;
    loc_code_i = 5'd12; loc_dir_i = 1;
    @(negedge clk_i);
    loc_acc_i = 0; loc_err_i = 0;
    rd_chk("R2 local flag set", 3'd0, 32'h2);
    chk("R4 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i);
    chk("R4 irq one cycle later", {31'b0, irq_o}, 32'h1);
    rd_chk("R5 error address kept", 3'd4, 32'hDEAD_0040);
    loc_cyc(0, 1, 0, 32'h0, 5'd0, 0);
    loc_cyc(1, 0, 0, 32'h0000_5000, 5'd21, 0);
    rd_chk("R5 local addr frozen", 3'd4, 32'hDEAD_0040);
    rd_chk("R8 local id frozen", 3'd5, 32'h0000_002C);
    loc_cyc(0, 1, 0, 32'h0, 5'd0, 0);
  endtask

  task automatic t_clear;
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 32'h2; loc_err_i = 1;
    @(negedge clk_i);
    reg_we_i = 0; loc_err_i = 0;
    rd_chk("R3 set beats clear", 3'd0, 32'h2);
    wr(3'd0, 32'h2);
    rd_chk("R2 write one clears", 3'd0, 32'h0);
    chk("R4 irq drops one cycle later", {31'b0, irq_o}, 32'h1);
    @(negedge clk_i);
    chk("R4 irq dropped", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_primary;
    pri_cyc(1, 0, 1, 32'hAAAA_0001, 5'd4, 0);
    rd_chk("R6 primary addr on error", 3'd2, 32'hAAAA_0001);
    rd_chk("R7 primary id", 3'd3, 32'h0000_0004);
    rd_chk("R2 primary flag", 3'd0, 32'h1);
    @(negedge clk_i);
    chk("R4 primary masked off", {31'b0, irq_o}, 32'h0);
    wr(3'd1, 32'h1);
    @(negedge clk_i);
    chk("R4 primary unmasked", {31'b0, irq_o}, 32'h1);
    pri_cyc(0, 0, 1, 32'hBBBB_0002, 5'd0, 0);
    rd_chk("R6 primary frozen while set", 3'd2, 32'hAAAA_0001);
    wr(3'd0, 32'h1);
    pri_cyc(0, 1, 0, 32'h0, 5'd0, 0);
    pri_cyc(1, 0, 0, 32'hCCCC_0003, 5'd30, 1);
    rd_chk("R6 primary ignores plain access", 3'd2, 32'hAAAA_0001);
    rd_chk("R7 primary id rx", 3'd3, 32'h0000_003E);
    pri_cyc(0, 1, 1, 32'hDDDD_0004, 5'd0, 0);
    rd_chk("R6 primary second error", 3'd2, 32'hDDDD_0004);
    wr(3'd0, 32'h1);
  endtask

  task automatic t_readonly;
    wr(3'd2, 32'h1234_5678);
    rd_chk("R9 primary addr write ignored", 3'd2, 32'hDDDD_0004);
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk("R9 local id write ignored", 3'd5, 32'h0000_002C);
    wr(3'd4, 32'h0);
    rd_chk("R9 local addr write ignored", 3'd4, 32'hDEAD_0040);
    rd_chk("R9 unmapped word 6", 3'd6, 32'h0);
    rd_chk("R9 unmapped word 7", 3'd7, 32'h0);
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset;
        #20 rst_ni = 1'b1;
        t_mask_rw;
        t_loc_track;
        t_loc_err;
        t_clear;
        t_primary;
        t_readonly;
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule